// File: doc/BRIEF.md
# Register Selection Prefix Tracker

This block holds the prefix state of a coprocessor with sixteen general registers. It sees each instruction as it completes. A one-byte prefix instruction can steer the register selection of the instruction that follows it. The block keeps the source index, the destination index and a "paired selection" flag, and other logic uses them to address its register file. One prefix group sets only the destination. The other group sets both the source and the destination, and it also raises the flag.

The block does not store register values. It watches where results land. When a completing instruction writes the program counter register (R15), it emits a one-cycle fetch-redirect strobe. When it writes the ROM pointer register (R14), it emits a one-cycle buffer-reload strobe. A selection lasts for exactly one instruction after its prefix, and then returns to R0.

While the paired flag is set, a destination-prefix opcode is not latched as a new prefix. It is treated as a register move into the register named by its low nibble. R11, R12 and R13 keep their usual roles as the link, loop-count and loop-address registers. They need no special handling here.

Top module: `prefix_decoder`

## Requirements
- R1: After reset, srcIdx and dstIdx are 0, bFlag is 0, and pcWrite and romReload are 0.
- R2: Opcode 0x1n completing while bFlag is 0 sets dstIdx to n. srcIdx and bFlag keep their values, and no strobe is raised.
- R3: Opcode 0x2n completing sets srcIdx and dstIdx to n and sets bFlag to 1. No strobe is raised. This holds whatever bFlag was before.
- R4: Any other non-zero opcode completing returns srcIdx and dstIdx to 0 and clears bFlag.
- R5: pcWrite is high for exactly the one cycle after the completing instruction writes register 15. The instruction can be a non-prefix opcode with writesDst=1 while dstIdx is 15, or a move into R15.
- R6: romReload behaves the same way as pcWrite, but for writes to register 14.
- R7: While bFlag is 1, opcode 0x1m is a move into Rm. It counts as a write to Rm whatever writesDst is. Nothing is latched, and afterwards the selection returns to R0 with bFlag clear.
- R8: Opcode 0x00 (stop) clears srcIdx, dstIdx and bFlag and raises no strobe. This holds even when writesDst is 1 and dstIdx is 15.
- R9: A cycle with instValid low changes no index and no flag, and both strobes are low in the following cycle.
- R10: pcWrite and romReload are never high together. A non-prefix opcode with writesDst=0 raises neither strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| instValid | input | 1 | An instruction completes in this cycle |
| opcode | input | 8 | Opcode of the completing instruction |
| writesDst | input | 1 | The completing non-prefix instruction writes its destination register |
| srcIdx | output | 4 | Current source register index |
| dstIdx | output | 4 | Current destination register index |
| bFlag | output | 1 | Paired source/destination selection active |
| pcWrite | output | 1 | One-cycle strobe: R15 was written, so fetch is redirected |
| romReload | output | 1 | One-cycle strobe: R14 was written, so the ROM buffer reloads |

## Verification
The hardest case to reach is the move form. A destination-prefix opcode must arrive while the paired flag is still up, and that only happens directly after a both-register prefix. The stimulus pairs every both-register prefix with every destination-prefix opcode, which gives 256 two-instruction sequences. Each sequence is checked for the strobe expected from the move target and for the return to R0. Every destination prefix is also followed by a writing and a non-writing plain opcode. A stop is issued while a pending R15 write is armed.

// File: rtl/prefix_pkg.sv
`timescale 1ns/1ps
package prefix_pkg;
  localparam int IDX_W = 4;
  localparam int REG_COUNT = 1 << IDX_W;
  localparam int OP_W = 8;
  localparam int GRP_W = OP_W - IDX_W;

  typedef logic [IDX_W-1:0] regIdx_t;

  // Command from control to the selection datapath
  typedef struct packed {
    logic    loadDst;
    logic    loadSrc;
    logic    setB;
    logic    clearSel;
    logic    hitPc;
    logic    hitRom;
    regIdx_t newIdx;
  } selCmd_t;
endpackage

// File: rtl/prefix_ctrl.sv
`timescale 1ns/1ps
module prefix_ctrl
  import prefix_pkg::*;
#(
  parameter int PC_IDX = 15,
  parameter int ROM_IDX = 14,
  parameter logic [GRP_W-1:0] TO_GRP = 4'h1,
  parameter logic [GRP_W-1:0] WITH_GRP = 4'h2,
  parameter logic [OP_W-1:0] STOP_OP = 8'h00
) (
  input  logic            instValid,
  input  logic [OP_W-1:0] opcode,
  input  logic            writesDst,
  input  logic            bFlag,
  input  regIdx_t         dstIdx,
  output selCmd_t         cmd
);
  logic isStop, isTo, isWith, isMove, doWrite;
  regIdx_t wrTarget;
  logic [REG_COUNT-1:0] regHit;

  assign isStop = instValid && (opcode == STOP_OP);
  assign isTo   = instValid && (opcode[OP_W-1:IDX_W] == TO_GRP);
  assign isWith = instValid && (opcode[OP_W-1:IDX_W] == WITH_GRP);
  assign isMove = isTo && bFlag;

  // A move writes the register named by its low nibble; others write dstIdx
  assign wrTarget = isMove ? opcode[IDX_W-1:0] : dstIdx;
  assign doWrite  = instValid && !isStop && !isWith && (isMove || (!isTo && writesDst));

  genvar gi;
  generate
    for (gi = 0; gi < REG_COUNT; gi++) begin : g_hit
      assign regHit[gi] = doWrite && (wrTarget == regIdx_t'(gi));
    end
  endgenerate

  always_comb begin
    cmd = '0;
    cmd.newIdx = opcode[IDX_W-1:0];
    if (instValid) begin
      if (isStop) begin
        cmd.clearSel = 1'b1;
      end else if (isWith) begin
        cmd.loadSrc = 1'b1;
        cmd.loadDst = 1'b1;
        cmd.setB    = 1'b1;
      end else if (isTo && !bFlag) begin
        cmd.loadDst = 1'b1;
      end else begin
        cmd.clearSel = 1'b1;
        cmd.hitPc    = regHit[PC_IDX];
        cmd.hitRom   = regHit[ROM_IDX];
      end
    end
  end
endmodule

// File: rtl/prefix_dpath.sv
`timescale 1ns/1ps
module prefix_dpath
  import prefix_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  selCmd_t cmd,
  output regIdx_t srcIdx,
  output regIdx_t dstIdx,
  output logic    bFlag,
  output logic    pcWrite,
  output logic    romReload
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srcIdx    <= '0;
      dstIdx    <= '0;
      bFlag     <= 1'b0;
      pcWrite   <= 1'b0;
      romReload <= 1'b0;
    end else begin
      pcWrite   <= cmd.hitPc;
      romReload <= cmd.hitRom;
      if (cmd.clearSel) begin
        srcIdx <= '0;
        dstIdx <= '0;
        bFlag  <= 1'b0;
      end else begin
        if (cmd.loadSrc) srcIdx <= cmd.newIdx;
        if (cmd.loadDst) dstIdx <= cmd.newIdx;
        if (cmd.setB)    bFlag  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/prefix_decoder.sv
`timescale 1ns/1ps
module prefix_decoder
  import prefix_pkg::*;
#(
  parameter int PC_IDX = 15,
  parameter int ROM_IDX = 14
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            instValid,
  input  logic [OP_W-1:0] opcode,
  input  logic            writesDst,
  output logic [IDX_W-1:0] srcIdx,
  output logic [IDX_W-1:0] dstIdx,
  output logic            bFlag,
  output logic            pcWrite,
  output logic            romReload
);
  selCmd_t cmd;

  prefix_ctrl #(.PC_IDX(PC_IDX), .ROM_IDX(ROM_IDX)) u_ctrl (
    .instValid(instValid),
    .opcode(opcode),
    .writesDst(writesDst),
    .bFlag(bFlag),
    .dstIdx(dstIdx),
    .cmd(cmd)
  );

  prefix_dpath u_dpath (
    .clk(clk),
    .rst_n(rst_n),
    .cmd(cmd),
    .srcIdx(srcIdx),
    .dstIdx(dstIdx),
    .bFlag(bFlag),
    .pcWrite(pcWrite),
    .romReload(romReload)
  );
endmodule

// File: rtl/prefix_decoder_chk.sv
`timescale 1ns/1ps
module prefix_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       instValid,
  input logic [7:0] opcode,
  input logic       writesDst,
  input logic [3:0] srcIdx,
  input logic [3:0] dstIdx,
  input logic       bFlag,
  input logic       pcWrite,
  input logic       romReload
);
  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(pcWrite && romReload));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !instValid |=> $stable(srcIdx) && $stable(dstIdx) && $stable(bFlag) && !pcWrite && !romReload);

  p_with_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    instValid && opcode[7:4] == 4'h2 |=> bFlag && srcIdx == $past(opcode[3:0]) && dstIdx == $past(opcode[3:0]));

  p_stop_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    instValid && opcode == 8'h00 |=> srcIdx == 4'd0 && dstIdx == 4'd0 && !bFlag && !pcWrite && !romReload);

  p_to_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    instValid && opcode[7:4] == 4'h1 && !bFlag |=> dstIdx == $past(opcode[3:0]) && $stable(srcIdx) && !pcWrite);

  p_move_r7: assert property (@(posedge clk) disable iff (!rst_n)
    instValid && opcode == 8'h1F && bFlag |=> pcWrite && !bFlag && dstIdx == 4'd0);

  p_pc_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pcWrite |-> $past(instValid));
endmodule

bind prefix_decoder prefix_decoder_chk u_chk (.*);

// File: tb/prefix_decoder_bench.sv
`timescale 1ns/1ps
module prefix_decoder_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic instValid = 1'b0;
  logic [7:0] opcode = 8'h01;
  logic writesDst = 1'b0;
  logic [3:0] srcIdx, dstIdx;
  logic bFlag, pcWrite, romReload;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  prefix_decoder u_prefix_decoder (
    .clk(clk), .rst_n(rst_n), .instValid(instValid), .opcode(opcode),
    .writesDst(writesDst), .srcIdx(srcIdx), .dstIdx(dstIdx), .bFlag(bFlag),
    .pcWrite(pcWrite), .romReload(romReload)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive one completing instruction at a falling edge; return at the next falling edge
  task automatic issue(input logic [7:0] op, input logic wr);
    instValid = 1'b1;
    opcode = op;
    writesDst = wr;
    @(negedge clk);
    instValid = 1'b0;
    writesDst = 1'b0;
  endtask

  task automatic expSel(input string req, input int s, input int d, input int b, input int pc, input int rom);
    chk({req, " src"}, srcIdx, s);
    chk({req, " dst"}, dstIdx, d);
    chk({req, " b"}, bFlag, b);
    chk({req, " pcWrite"}, pcWrite, pc);
    chk({req, " romReload"}, romReload, rom);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    expSel("R1 reset", 0, 0, 0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    expSel("R1 after release", 0, 0, 0, 0, 0);

    // Destination prefix, then a writing and a non-writing plain opcode
    for (int n = 0; n < 16; n++) begin
      issue(8'h10 | 8'(n), 1'b0);
      expSel("R2 to", 0, n, 0, 0, 0);
      issue(8'h3C, 1'b1);
      expSel("R5/R6 plain write", 0, 0, 0, int'(n == 15), int'(n == 14));
      issue(8'h10 | 8'(n), 1'b0);
      issue(8'h3C, 1'b0);
      expSel("R10 no write R4", 0, 0, 0, 0, 0);
    end

    // Both-register prefix followed by every destination-prefix opcode (move)
    for (int n = 0; n < 16; n++) begin
      for (int m = 0; m < 16; m++) begin
        issue(8'h20 | 8'(n), 1'b0);
        expSel("R3 with", n, n, 1, 0, 0);
        issue(8'h10 | 8'(m), 1'b0);
        expSel("R7 move", 0, 0, 0, int'(m == 15), int'(m == 14));
      end
    end

    // Both-register prefix, then a plain opcode that writes the paired register
    for (int n = 0; n < 16; n++) begin
      issue(8'h20 | 8'(n), 1'b0);
      issue(8'h50, 1'b1);
      expSel("R4 with plain", 0, 0, 0, int'(n == 15), int'(n == 14));
    end

    // Source index is kept by a destination prefix; a second prefix overrides
    issue(8'h27, 1'b0);
    issue(8'h23, 1'b0);
    expSel("R3 with over with", 3, 3, 1, 0, 0);
    issue(8'h04, 1'b0);
    issue(8'h1E, 1'b0);
    issue(8'h1F, 1'b0);
    expSel("R2 to over to", 0, 15, 0, 0, 0);

    // Idle cycles hold state and raise nothing
    repeat (4) @(negedge clk);
    expSel("R9 idle", 0, 15, 0, 0, 0);

    // Stop with an armed R15 write
    issue(8'h00, 1'b1);
    expSel("R8 stop after to", 0, 0, 0, 0, 0);
    issue(8'h2F, 1'b0);
    issue(8'h00, 1'b1);
    expSel("R8 stop after with", 0, 0, 0, 0, 0);

    // Strobe lasts a single cycle
    issue(8'h1F, 1'b0);
    issue(8'h3C, 1'b1);
    chk("R5 pulse", pcWrite, 1);
    @(negedge clk);
    chk("R5 pulse end", pcWrite, 0);
    issue(8'h1E, 1'b0);
    issue(8'h3C, 1'b1);
    chk("R6 pulse", romReload, 1);
    @(negedge clk);
    chk("R6 pulse end", romReload, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule